// File: doc/BRIEF.md
# Address Translation Cache with Pinned Entries

This block caches virtual-to-physical translations for both instruction and data fetches in a single array. It has two storage regions that are searched in parallel on every lookup. The first is a two-way, sixteen-set array that page-table walks fill. The second is an eight-slot fully associative pinned region. Translations placed in the pinned region survive a global flush, which makes it suitable for mappings that must never miss.

A small pin-control register decides where each walk fill lands. When its pin bit is clear, fills go to the set-associative array. In that array a fill replaces a way chosen by a round-robin pointer kept for each set. When the pin bit is set, the fill goes to the slot the register names, and the slot index then advances by one.

Lookups are combinational from the stored state. A fill, invalidate or register write takes effect at the next rising clock edge.

Top module: `tlb_lock_top`

## Requirements
- R1: After reset no lookup hits, `look_pay` reads zero on a miss, and `lkreg_q` reads 0.
- R2: With the pin bit (bit 3 of the pin-control register) clear, a fill enters the set-associative array. From the next cycle on, a lookup of that page hits and returns the filled payload.
- R3: The set-associative array has 2 ways and 16 sets, and the set index is page bits [3:0]. Each set keeps a round-robin pointer that starts at way 0 and advances on every fill that allocates a way. A third distinct page filled into one set therefore evicts the first one, and other sets are untouched.
- R4: A fill whose page is already held in its set overwrites that way's payload in place and does not advance the set's pointer.
- R5: With the pin bit set, a fill writes the pinned slot given by register bits [2:0]. Those bits then increment modulo 8, so 7 wraps to 0, and the new value is visible on `lkreg_q`.
- R6: The pinned region holds eight fully associative entries. Eight distinct pages that share one set index can all be held at the same time.
- R7: A global flush is raised by any bit of `inv_all_req` (bit 0 unified, bit 1 instruction side, bit 2 data side). It clears every set-associative entry and leaves every valid pinned entry intact.
- R8: A single-page invalidate is raised by any bit of `inv_one_req`, with the same bit meaning as R7. It removes the page `inv_vpn` from both regions, the pinned region included, and no other entry changes.
- R9: When both regions hold the looked-up page, the pinned payload is returned. If two pinned slots hold it, the lower slot number wins.
- R10: When operations coincide in one cycle, invalidates are applied before the fill. A fill in the same cycle as a register write uses the old register value, and the written value replaces the increment.
- R11: While the pin bit is clear, fills leave every pinned entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| look_vpn | input | 20 | Virtual page number to translate |
| look_hit | output | 1 | Lookup found a valid entry |
| look_pay | output | 24 | Translation payload, zero on a miss |
| fill_req | input | 1 | Walk fill strobe |
| fill_vpn | input | 20 | Page number of the fill |
| fill_pay | input | 24 | Payload of the fill |
| inv_all_req | input | 3 | Global flush strobes: unified, instruction, data |
| inv_one_req | input | 3 | Single-page invalidate strobes: unified, instruction, data |
| inv_vpn | input | 20 | Page number for a single-page invalidate |
| lkreg_wr | input | 1 | Write strobe for the pin-control register |
| lkreg_wdata | input | 4 | Bit 3 pin, bits [2:0] slot index |
| lkreg_q | output | 4 | Current pin-control register value |

## Verification
The bench chases three kinds of corner case. The first is the flush asymmetry: a design that cleared pinned entries on a global flush, or that ignored pinned entries on a single-page invalidate, would show wrong hits right after those strobes. The second is replacement order. It covers a full set with a round-robin pointer, an in-place refill that must not advance the pointer, and the slot index wrapping from 7 to 0; a wrong pointer evicts the wrong page, and a wrong wrap overwrites a live pinned slot. The third is same-cycle collisions between a flush and a fill, and between a register write and a fill. Duplicate entries across the regions and within the pinned region are also covered, where a wrong priority returns the stale payload.

// File: rtl/tlb_lock_pkg.sv
package tlb_lock_pkg;

  // Next value of a modulo-n counter.
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1) % n;
  endfunction

  // Set index of a page number for a power-of-two set count.
  function automatic int unsigned set_of(int unsigned vpn, int unsigned sets);
    return vpn % sets;
  endfunction

  typedef enum logic [1:0] {
    FT_NONE = 2'd0,
    FT_SA   = 2'd1,
    FT_LOCK = 2'd2
  } fill_tgt_e;

endpackage

// File: rtl/tlb_sa_array.sv
module tlb_sa_array
  import tlb_lock_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PAY_W = 24,
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output logic [PAY_W-1:0] look_pay,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PAY_W-1:0] fill_pay,
  input  logic             clr_all,
  input  logic             clr_one,
  input  logic [VPN_W-1:0] clr_vpn,
  output logic             any_valid
);

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [PAY_W-1:0] pay_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  valid_d [SETS];
  logic [PTR_W-1:0] rr_q    [SETS];

  logic [IDX_W-1:0] look_set, fill_set, clr_set;
  logic [TAG_W-1:0] look_tag, fill_tag, clr_tag;
  logic [WAYS-1:0]  clr_match, fill_kill, fill_match;
  logic [PTR_W-1:0] fill_way;
  logic             fill_alloc;

  assign look_set = look_vpn[IDX_W-1:0];
  assign look_tag = look_vpn[VPN_W-1:IDX_W];
  assign fill_set = fill_vpn[IDX_W-1:0];
  assign fill_tag = fill_vpn[VPN_W-1:IDX_W];
  assign clr_set  = clr_vpn[IDX_W-1:0];
  assign clr_tag  = clr_vpn[VPN_W-1:IDX_W];

  // Lookup: the lowest matching way wins; duplicates are never created.
  always_comb begin
    look_hit = 1'b0;
    look_pay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid_q[look_set][w] && tag_q[look_set][w] == look_tag) begin
        look_hit = 1'b1;
        look_pay = pay_q[look_set][w];
      end
    end
  end

  // Ways hit by the invalidate, and fill matching on the post-invalidate state.
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      clr_match[w]  = valid_q[clr_set][w] && (tag_q[clr_set][w] == clr_tag);
      fill_kill[w]  = clr_all || (clr_one && (clr_set == fill_set) && clr_match[w]);
      fill_match[w] = valid_q[fill_set][w] && !fill_kill[w] &&
                      (tag_q[fill_set][w] == fill_tag);
    end
  end

  always_comb begin
    fill_way = rr_q[fill_set];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (fill_match[w]) fill_way = PTR_W'(w);
    end
  end

  assign fill_alloc = fill_en && !(|fill_match);

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      valid_d[s] = clr_all ? '0 : valid_q[s];
      if (clr_one && clr_set == IDX_W'(s)) valid_d[s] = valid_d[s] & ~clr_match;
      if (fill_en && fill_set == IDX_W'(s)) valid_d[s][fill_way] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= valid_d[s];
      if (fill_alloc)
        rr_q[fill_set] <= PTR_W'(wrap_inc(int'(rr_q[fill_set]), WAYS));
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_set][fill_way] <= fill_tag;
      pay_q[fill_set][fill_way] <= fill_pay;
    end
  end

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
  end

endmodule

// File: rtl/tlb_lock_bank.sv
module tlb_lock_bank #(
  parameter int VPN_W  = 20,
  parameter int PAY_W  = 24,
  parameter int LOCK_N = 8,
  localparam int LK_IDX_W = $clog2(LOCK_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VPN_W-1:0]    look_vpn,
  output logic                look_hit,
  output logic [PAY_W-1:0]    look_pay,
  input  logic                wr_en,
  input  logic [LK_IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [PAY_W-1:0]    wr_pay,
  input  logic                clr_one,
  input  logic [VPN_W-1:0]    clr_vpn,
  output logic [LOCK_N-1:0]   valid_vec
);

  logic [LOCK_N-1:0] match;
  logic [PAY_W-1:0]  pay_arr [LOCK_N];

  for (genvar i = 0; i < LOCK_N; i++) begin : g_ent
    logic             v_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PAY_W-1:0] pay_q;
    logic             sel, kill;

    assign sel  = wr_en && (wr_idx == LK_IDX_W'(i));
    assign kill = clr_one && v_q && (vpn_q == clr_vpn);

    // A write in the same cycle as a clear wins: the invalidate comes first.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    v_q <= 1'b0;
      else if (sel)  v_q <= 1'b1;
      else if (kill) v_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        vpn_q <= wr_vpn;
        pay_q <= wr_pay;
      end
    end

    assign valid_vec[i] = v_q;
    assign match[i]     = v_q && (vpn_q == look_vpn);
    assign pay_arr[i]   = pay_q;
  end

  // Lowest-numbered matching slot wins.
  always_comb begin
    look_hit = 1'b0;
    look_pay = '0;
    for (int i = LOCK_N - 1; i >= 0; i--) begin
      if (match[i]) begin
        look_hit = 1'b1;
        look_pay = pay_arr[i];
      end
    end
  end

endmodule

// File: rtl/tlb_lock_ctrl.sv
module tlb_lock_ctrl
  import tlb_lock_pkg::*;
#(
  parameter int LOCK_N = 8,
  localparam int LK_IDX_W = $clog2(LOCK_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [LK_IDX_W:0]   reg_wdata,
  input  logic                fill_req,
  output logic [LK_IDX_W:0]   reg_q,
  output logic [LK_IDX_W-1:0] victim,
  output fill_tgt_e           fill_tgt
);

  logic                pin_q;
  logic [LK_IDX_W-1:0] vic_q;

  always_comb begin
    if (!fill_req)  fill_tgt = FT_NONE;
    else if (pin_q) fill_tgt = FT_LOCK;
    else            fill_tgt = FT_SA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      vic_q <= '0;
    end else if (reg_wr) begin
      pin_q <= reg_wdata[LK_IDX_W];
      vic_q <= reg_wdata[LK_IDX_W-1:0];
    end else if (fill_tgt == FT_LOCK) begin
      vic_q <= LK_IDX_W'(wrap_inc(int'(vic_q), LOCK_N));
    end
  end

  assign reg_q  = {pin_q, vic_q};
  assign victim = vic_q;

endmodule

// File: rtl/tlb_lock_top.sv
module tlb_lock_top
  import tlb_lock_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PAY_W  = 24,
  parameter int SETS   = 16,
  parameter int WAYS   = 2,
  parameter int LOCK_N = 8,
  localparam int LK_IDX_W = $clog2(LOCK_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VPN_W-1:0]    look_vpn,
  output logic                look_hit,
  output logic [PAY_W-1:0]    look_pay,
  input  logic                fill_req,
  input  logic [VPN_W-1:0]    fill_vpn,
  input  logic [PAY_W-1:0]    fill_pay,
  input  logic [2:0]          inv_all_req,
  input  logic [2:0]          inv_one_req,
  input  logic [VPN_W-1:0]    inv_vpn,
  input  logic                lkreg_wr,
  input  logic [LK_IDX_W:0]   lkreg_wdata,
  output logic [LK_IDX_W:0]   lkreg_q
);

  // Named internal events, also watched by the checker.
  logic                inv_all_any, inv_one_any;
  logic                fill_lock, fill_sa;
  logic [LK_IDX_W-1:0] victim;
  fill_tgt_e           fill_tgt;
  logic                sa_hit, lock_hit, sa_any_valid;
  logic [PAY_W-1:0]    sa_pay, lock_pay;
  logic [LOCK_N-1:0]   lock_valid;

  // One array serves both sides, so the side strobes merge.
  assign inv_all_any = |inv_all_req;
  assign inv_one_any = |inv_one_req;
  assign fill_lock   = (fill_tgt == FT_LOCK);
  assign fill_sa     = (fill_tgt == FT_SA);

  tlb_lock_ctrl #(.LOCK_N(LOCK_N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (lkreg_wr),
    .reg_wdata(lkreg_wdata),
    .fill_req (fill_req),
    .reg_q    (lkreg_q),
    .victim   (victim),
    .fill_tgt (fill_tgt)
  );

  tlb_sa_array #(.VPN_W(VPN_W), .PAY_W(PAY_W), .SETS(SETS), .WAYS(WAYS)) u_sa (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_vpn (look_vpn),
    .look_hit (sa_hit),
    .look_pay (sa_pay),
    .fill_en  (fill_sa),
    .fill_vpn (fill_vpn),
    .fill_pay (fill_pay),
    .clr_all  (inv_all_any),
    .clr_one  (inv_one_any),
    .clr_vpn  (inv_vpn),
    .any_valid(sa_any_valid)
  );

  tlb_lock_bank #(.VPN_W(VPN_W), .PAY_W(PAY_W), .LOCK_N(LOCK_N)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_vpn (look_vpn),
    .look_hit (lock_hit),
    .look_pay (lock_pay),
    .wr_en    (fill_lock),
    .wr_idx   (victim),
    .wr_vpn   (fill_vpn),
    .wr_pay   (fill_pay),
    .clr_one  (inv_one_any),
    .clr_vpn  (inv_vpn),
    .valid_vec(lock_valid)
  );

  // The pinned region has priority over the set-associative array.
  always_comb begin
    look_hit = lock_hit | sa_hit;
    if (lock_hit)    look_pay = lock_pay;
    else if (sa_hit) look_pay = sa_pay;
    else             look_pay = '0;
  end

endmodule

// File: rtl/tlb_lock_chk.sv
module tlb_lock_chk #(
  parameter int LOCK_N = 8,
  localparam int LK_IDX_W = $clog2(LOCK_N)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inv_all_any,
  input logic                inv_one_any,
  input logic                fill_lock,
  input logic                fill_sa,
  input logic                lkreg_wr,
  input logic [LK_IDX_W-1:0] victim,
  input logic [LOCK_N-1:0]   lock_valid,
  input logic                sa_any_valid,
  input logic                look_hit
);

  p_flush_empties_sa_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_any && !fill_sa |=> !sa_any_valid);

  p_flush_keeps_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_any && !inv_one_any && !fill_lock |=> lock_valid == $past(lock_valid));

  p_slot_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lock && !lkreg_wr |=> victim == LK_IDX_W'($past(victim) + 1'b1));

  p_pin_fill_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lock |=> |lock_valid);

  p_sa_fill_spares_pins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_sa && !inv_one_any |=> lock_valid == $past(lock_valid));

  p_hit_has_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    look_hit |-> (sa_any_valid || (|lock_valid)));

endmodule

bind tlb_lock_top tlb_lock_chk #(.LOCK_N(LOCK_N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .inv_all_any (inv_all_any),
  .inv_one_any (inv_one_any),
  .fill_lock   (fill_lock),
  .fill_sa     (fill_sa),
  .lkreg_wr    (lkreg_wr),
  .victim      (victim),
  .lock_valid  (lock_valid),
  .sa_any_valid(sa_any_valid),
  .look_hit    (look_hit)
);

// File: tb/sim_tlb_lock_top.sv
module sim_tlb_lock_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] look_vpn = '0;
  logic        look_hit;
  logic [23:0] look_pay;
  logic        fill_req = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [23:0] fill_pay = '0;
  logic [2:0]  inv_all_req = '0;
  logic [2:0]  inv_one_req = '0;
  logic [19:0] inv_vpn = '0;
  logic        lkreg_wr = 1'b0;
  logic [3:0]  lkreg_wdata = '0;
  logic [3:0]  lkreg_q;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tlb_lock_top u0 (.*);

  // Behavioural reference: a list of pinned records and a per-set way list.
  int  m_sa_vpn [16][2];
  int  m_sa_pay [16][2];
  bit  m_sa_v   [16][2];
  int  m_rr     [16];
  int  m_pin_vpn [8];
  int  m_pin_pay [8];
  bit  m_pin_v   [8];
  bit  m_pin;
  int  m_slot;

  task automatic model_reset();
    for (int s = 0; s < 16; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 2; w++) m_sa_v[s][w] = 0;
    end
    for (int i = 0; i < 8; i++) m_pin_v[i] = 0;
    m_pin = 0;
    m_slot = 0;
  endtask

  task automatic model_look(input int vpn, output bit hit, output int pay);
    hit = 0;
    pay = 0;
    for (int i = 0; i < 8 && !hit; i++)
      if (m_pin_v[i] && m_pin_vpn[i] == vpn) begin hit = 1; pay = m_pin_pay[i]; end
    for (int w = 0; w < 2 && !hit; w++)
      if (m_sa_v[vpn % 16][w] && m_sa_vpn[vpn % 16][w] == vpn) begin
        hit = 1; pay = m_sa_pay[vpn % 16][w];
      end
  endtask

  task automatic model_clock();
    int s;
    int way;
    if (inv_all_req != 0)
      for (int k = 0; k < 16; k++) for (int w = 0; w < 2; w++) m_sa_v[k][w] = 0;
    if (inv_one_req != 0) begin
      for (int k = 0; k < 16; k++) for (int w = 0; w < 2; w++)
        if (m_sa_v[k][w] && m_sa_vpn[k][w] == int'(inv_vpn)) m_sa_v[k][w] = 0;
      for (int i = 0; i < 8; i++)
        if (m_pin_v[i] && m_pin_vpn[i] == int'(inv_vpn)) m_pin_v[i] = 0;
    end
    if (fill_req) begin
      if (m_pin) begin
        m_pin_v[m_slot] = 1;
        m_pin_vpn[m_slot] = int'(fill_vpn);
        m_pin_pay[m_slot] = int'(fill_pay);
      end else begin
        s = int'(fill_vpn) % 16;
        way = -1;
        for (int w = 1; w >= 0; w--)
          if (m_sa_v[s][w] && m_sa_vpn[s][w] == int'(fill_vpn)) way = w;
        if (way < 0) begin
          way = m_rr[s];
          m_rr[s] = (m_rr[s] + 1) % 2;
        end
        m_sa_v[s][way] = 1;
        m_sa_vpn[s][way] = int'(fill_vpn);
        m_sa_pay[s][way] = int'(fill_pay);
      end
    end
    if (lkreg_wr) begin
      m_pin = lkreg_wdata[3];
      m_slot = int'(lkreg_wdata[2:0]);
    end else if (fill_req && m_pin) begin
      m_slot = (m_slot + 1) % 8;
    end
  endtask

  // Compare outputs mid-cycle, then advance the model across the rising edge.
  task automatic tick(input string req, input int vpn);
    bit ehit;
    int epay;
    look_vpn = vpn[19:0];
    #2;
    model_look(vpn, ehit, epay);
    checks++;
    if (look_hit !== ehit || int'(look_pay) !== epay || int'(lkreg_q) !== ((m_pin ? 8 : 0) + m_slot)) begin
      errors++;
      $display("FAIL %s vpn=%h: hit=%0b pay=%h reg=%h, expected hit=%0b pay=%h reg=%h",
               req, vpn, look_hit, look_pay, lkreg_q, ehit, epay[23:0],
               (m_pin ? 8 : 0) + m_slot);
    end
    @(posedge clk);
    if (rst_n) model_clock();
    @(negedge clk);
    fill_req = 0;
    inv_all_req = '0;
    inv_one_req = '0;
    lkreg_wr = 0;
  endtask

  task automatic do_fill(input string req, input int vpn, input int pay);
    fill_req = 1;
    fill_vpn = vpn[19:0];
    fill_pay = pay[23:0];
    tick(req, vpn);
  endtask

  task automatic set_reg(input string req, input bit pin, input int slot);
    lkreg_wr = 1;
    lkreg_wdata = {pin, slot[2:0]};
    tick(req, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: empty after reset
    tick("R1", 20'h00000);
    tick("R1", 20'h12345);
    // R2: fill to set-associative array, then hit
    do_fill("R2", 20'h00012, 24'hA00012);
    tick("R2", 20'h00012);
    tick("R2", 20'h00013);
    // R3: round-robin in set 2, other sets untouched
    do_fill("R3", 20'h00022, 24'hB00022);
    do_fill("R3", 20'h00005, 24'hC00005);
    do_fill("R3", 20'h00032, 24'hD00032);
    tick("R3", 20'h00012);
    tick("R3", 20'h00022);
    tick("R3", 20'h00032);
    tick("R3", 20'h00005);
    // R4: in-place refill does not advance the pointer
    do_fill("R4", 20'h00022, 24'hB1B1B1);
    tick("R4", 20'h00022);
    do_fill("R4", 20'h00042, 24'hE00042);
    tick("R4", 20'h00022);
    tick("R4", 20'h00032);
    tick("R4", 20'h00042);
    // R5: pinned fills starting at slot 6 wrap to 0
    set_reg("R5", 1, 6);
    do_fill("R5", 20'h10007, 24'h500006);
    do_fill("R5", 20'h20007, 24'h500007);
    do_fill("R5", 20'h30007, 24'h500000);
    tick("R5", 20'h10007);
    tick("R5", 20'h30007);
    // R6: eight pinned entries sharing set 7
    set_reg("R6", 1, 0);
    for (int i = 0; i < 8; i++) do_fill("R6", 20'h40007 + (i << 8), 24'h600000 + i);
    for (int i = 0; i < 8; i++) tick("R6", 20'h40007 + (i << 8));
    tick("R6", 20'h10007);
    // R11: unpinned fills spare pinned entries
    set_reg("R11", 0, 3);
    do_fill("R11", 20'h40207, 24'h777777);
    do_fill("R11", 20'h00057, 24'h888888);
    for (int i = 0; i < 8; i++) tick("R11", 20'h40007 + (i << 8));
    // R9: both regions hold 0x40207; pinned payload wins
    tick("R9", 20'h40207);
    // R9: duplicate pinned slots, lower slot wins
    set_reg("R9", 1, 5);
    do_fill("R9", 20'h40107, 24'h999999);
    tick("R9", 20'h40107);
    // R7: flush via instruction-side bit keeps pinned entries
    inv_all_req = 3'b010;
    tick("R7", 20'h00022);
    tick("R7", 20'h00022);
    tick("R7", 20'h00057);
    tick("R7", 20'h40307);
    tick("R7", 20'h40207);
    // R8: single invalidate via data-side bit removes a pinned entry
    inv_one_req = 3'b100;
    inv_vpn = 20'h40307;
    tick("R8", 20'h40307);
    tick("R8", 20'h40307);
    tick("R8", 20'h40407);
    inv_one_req = 3'b001;
    inv_vpn = 20'h40107;
    tick("R8", 20'h40107);
    tick("R8", 20'h40107);
    // R10: flush and fill together keep the fill
    set_reg("R10", 0, 0);
    do_fill("R10", 20'h0000A, 24'hAAAAAA);
    inv_all_req = 3'b001;
    do_fill("R10", 20'h0000A, 24'hABABAB);
    tick("R10", 20'h0000A);
    // R10: register write with fill uses old value; written slot replaces increment
    set_reg("R10", 1, 2);
    lkreg_wr = 1;
    lkreg_wdata = 4'b1101;
    do_fill("R10", 20'h5000B, 24'h121212);
    tick("R10", 20'h5000B);
    do_fill("R10", 20'h6000B, 24'h131313);
    tick("R10", 20'h6000B);
    tick("R10", 20'h00000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule